// File: doc/BRIEF.md
# Guarded EEPROM Write Controller

This block sits between a processor's register port and a 512-byte byte-wide EEPROM array. The array is modelled as a synchronous memory whose writes take a fixed, timed number of cycles. Software loads an address register and a data register through the register port. It then writes the control register to read a byte, or to start a guarded write.

A write must be armed first. One control write sets the master-enable bit with write-enable clear. Write-enable must then arrive within four clock cycles, or the arming lapses and the write request does nothing.

While a byte is being programmed, the busy flag stays high for a parameterised number of cycles and then drops by itself. Software polls this flag. A stall output holds the processor for four cycles after a read and for two cycles after a write starts. Writes are refused while an external flash self-programming operation is busy.

Top module: `eeprom_wr_guard`

## Requirements
- R1: After reset, `armed`, `busy`, `stall` and `rd_err` are 0 and `rd_data` is 0.
- R2: A control write (`reg_sel`=2) with bit 2 (master-enable) set, bit 1 (write-enable) clear and bit 0 (read) clear raises `armed` on the next cycle. `armed` then falls by itself after exactly 4 cycles.
- R3: A control write with bit 1 set and bit 0 clear starts a write when all three of these hold: `armed` is 1, `busy` is 0 and `flash_busy` is 0. `busy` is 1 from the next cycle, and `armed` is cleared.
- R4: A write-enable control write that arrives when `armed` is 0, whether it was never armed or has timed out, has no effect. `busy` stays 0 and the stored byte is unchanged.
- R5: `busy` stays high for exactly WR_CYC cycles (default 20). The byte is stored at the end of that time.
- R6: Starting a write raises `stall` for exactly 2 cycles.
- R7: A control write with bit 0 set performs a read: `rd_data` shows the byte at the address register on the next cycle, and `stall` is high for exactly 4 cycles. The other control bits in that write are ignored.
- R8: A write-enable request made while `flash_busy` is 1 is ignored. `busy` stays 0 and the stored byte is unchanged.
- R9: The address register (`reg_sel`=0) and the data register (`reg_sel`=1, low 8 bits) may be loaded in either order. Any register that is not reloaded keeps its previous value for the next write.
- R10: Address or data writes made while `busy` is 1 do not change the byte being programmed or where it is stored.
- R11: A read requested while `busy` is 1 pulses `rd_err` for one cycle and leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| reg_wdata | input | 9 | Register write value |
| flash_busy | input | 1 | Flash self-programming in progress |
| armed | output | 1 | Master-enable currently set |
| busy | output | 1 | Write in progress (write-enable state) |
| stall | output | 1 | Processor hold request |
| rd_data | output | 8 | Last byte read |
| rd_err | output | 1 | One-cycle pulse on a read made during a write |

## Verification
The bench probes both edges of the arming window. Write-enable arriving on the fourth cycle after arming must start a write, and on the fifth cycle it must not. A design with an off-by-one window would either drop a legal write or accept a late one.

It counts `busy` and `stall` cycle by cycle, because an extra or missing cycle would break the software polling and stall timing. It also rewrites the address and data registers during programming and reads the array afterwards. A design that did not latch those values at the start would store the wrong byte at the wrong address.

Further tests cover a write refused while flash is busy, an early read that must raise an error and keep the old data, and a write that reuses the registers left over from before.

// File: rtl/eewg_pkg.sv
package eewg_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CB_READ = 0;
  localparam int CB_WEN  = 1;
  localparam int CB_MEN  = 2;

  // Stall length picked by access kind.
  function automatic int stall_cycles(input logic is_read, input int rd_len, input int wr_len);
    return is_read ? rd_len : wr_len;
  endfunction

  // Saturating down-count toward zero.
  function automatic logic [7:0] count_down(input logic [7:0] c);
    return (c == 8'd0) ? 8'd0 : c - 8'd1;
  endfunction
endpackage

// File: rtl/eewg_arm_timer.sv
module eewg_arm_timer #(
  parameter int ARM_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_req,
  input  logic consume,
  output logic armed
);
  import eewg_pkg::*;
  logic [7:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (arm_req)  cnt_q <= 8'(ARM_CYC);
    else if (consume)  cnt_q <= '0;
    else               cnt_q <= count_down(cnt_q);
  end

  assign armed = (cnt_q != 8'd0);

  a_r2_arm_rise: assert property (@(posedge clk) disable iff (!rst_n)
    arm_req |=> armed);
  a_r3_consume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> !armed);
endmodule

// File: rtl/eewg_prog_timer.sv
module eewg_prog_timer #(
  parameter int WR_CYC = 20,
  parameter int AW     = 9,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data
);
  localparam int CW = $clog2(WR_CYC + 1);
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(WR_CYC - 1);
      addr_q <= addr_in;
      data_q <= data_in;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy     = busy_q;
  assign mem_we   = busy_q && (cnt_q == '0);
  assign mem_addr = addr_q;
  assign mem_data = data_q;

  a_r5_commit_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !busy);
  a_r10_latched_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mem_addr) && $stable(mem_data)));
endmodule

// File: rtl/eewg_stall_gen.sv
module eewg_stall_gen #(
  parameter int RD_STALL = 4,
  parameter int WR_STALL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic is_read,
  output logic stall
);
  import eewg_pkg::*;
  logic [7:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= 8'(stall_cycles(is_read, RD_STALL, WR_STALL));
    else           cnt_q <= count_down(cnt_q);
  end

  assign stall = (cnt_q != 8'd0);

  a_r7_stall_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> stall);
endmodule

// File: rtl/eewg_mem.sv
module eewg_mem #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_wr_guard.sv
module eeprom_wr_guard #(
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 8,
  parameter int ARM_CYC  = 4,
  parameter int WR_CYC   = 20,
  parameter int RD_STALL = 4,
  parameter int WR_STALL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              flash_busy,
  output logic              armed,
  output logic              busy,
  output logic              stall,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_err
);
  import eewg_pkg::*;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] rd_q;
  logic              err_q;

  // Named internal events
  logic ctrl_wr, ev_read, ev_arm, ev_start;
  logic mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  assign ctrl_wr  = reg_wr && (reg_sel == SEL_CTRL);
  assign ev_read  = ctrl_wr && reg_wdata[CB_READ];
  assign ev_arm   = ctrl_wr && !reg_wdata[CB_READ] && reg_wdata[CB_MEN] && !reg_wdata[CB_WEN];
  assign ev_start = ctrl_wr && !reg_wdata[CB_READ] && reg_wdata[CB_WEN]
                    && armed && !busy && !flash_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (reg_wr && reg_sel == SEL_ADDR) addr_q <= reg_wdata;
      if (reg_wr && reg_sel == SEL_DATA) data_q <= reg_wdata[DATA_W-1:0];
      if (ev_read) begin
        if (busy) err_q <= 1'b1;
        else      rd_q  <= mem_rdata;
      end
    end
  end

  eewg_arm_timer #(.ARM_CYC(ARM_CYC)) u_arm (
    .clk(clk), .rst_n(rst_n), .arm_req(ev_arm), .consume(ev_start), .armed(armed)
  );

  eewg_prog_timer #(.WR_CYC(WR_CYC), .AW(ADDR_W), .DW(DATA_W)) u_prog (
    .clk(clk), .rst_n(rst_n), .start(ev_start), .addr_in(addr_q), .data_in(data_q),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_waddr), .mem_data(mem_wdata)
  );

  eewg_stall_gen #(.RD_STALL(RD_STALL), .WR_STALL(WR_STALL)) u_stall (
    .clk(clk), .rst_n(rst_n), .load(ev_read || ev_start), .is_read(ev_read), .stall(stall)
  );

  eewg_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(addr_q), .rdata(mem_rdata)
  );

  assign rd_data = rd_q;
  assign rd_err  = err_q;

  a_r4_start_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));
  a_r8_flash_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(flash_busy));
  a_r6_stall_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> stall);
  a_r11_err_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> $past(busy));
  a_r11_err_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> $stable(rd_data));
  a_r1_no_err_pair: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |=> !rd_err);
endmodule

// File: tb/eeprom_wr_guard_tb.sv
module eeprom_wr_guard_tb;
  localparam int WR_CYC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd3;
  logic [8:0] reg_wdata = '0;
  logic       flash_busy = 1'b0;
  logic       armed, busy, stall, rd_err;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  eeprom_wr_guard u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .flash_busy(flash_busy), .armed(armed), .busy(busy), .stall(stall),
    .rd_data(rd_data), .rd_err(rd_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one register write; return just after the capturing edge.
  task automatic wreg(input logic [1:0] sel, input logic [8:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && busy; i++) tick(1);
  endtask

  task automatic read_chk(input string req, input logic [8:0] a, input int exp);
    wreg(2'd0, a);
    wreg(2'd2, 9'b001);
    chk(req, "read data", rd_data, exp);
  endtask

  // R2 window, R3 start, R5 busy length, R6 stall
  task automatic t_basic_write();
    wreg(2'd0, 9'd300);
    wreg(2'd1, 9'h5A);
    wreg(2'd2, 9'b100);
    chk("R2", "armed after arm", armed, 1);
    tick(3);
    chk("R2", "armed still on at 3 cycles", armed, 1);
    wreg(2'd2, 9'b010);            // accepted at the last armed edge
    chk("R3", "busy after start", busy, 1);
    chk("R3", "armed consumed", armed, 0);
    chk("R6", "stall cycle 1", stall, 1);
    tick(1);
    chk("R6", "stall cycle 2", stall, 1);
    tick(1);
    chk("R6", "stall released", stall, 0);
    tick(WR_CYC - 3);
    chk("R5", "busy at last cycle", busy, 1);
    tick(1);
    chk("R5", "busy cleared", busy, 0);
    read_chk("R5", 9'd300, 8'h5A);
  endtask

  // R2 timeout, R4 late enable
  task automatic t_timeout();
    wreg(2'd0, 9'd7);
    wreg(2'd1, 9'h11);
    wreg(2'd2, 9'b100);
    tick(4);
    chk("R2", "armed expired after 4", armed, 0);
    wreg(2'd2, 9'b010);
    chk("R4", "late enable no busy", busy, 0);
    tick(WR_CYC + 2);
    chk("R4", "still idle", busy, 0);
    read_chk("R4", 9'd7, 8'h00);
    wreg(2'd1, 9'h22);
    wreg(2'd2, 9'b010);            // never armed
    chk("R4", "unarmed enable no busy", busy, 0);
    read_chk("R4", 9'd7, 8'h00);
  endtask

  // R7 read stall
  task automatic t_read_stall();
    wreg(2'd0, 9'd300);
    wreg(2'd2, 9'b111);            // read with other bits set
    chk("R7", "read value", rd_data, 8'h5A);
    chk("R7", "read ignores enable", busy, 0);
    chk("R7", "read ignores arm", armed, 0);
    tick(3);
    chk("R7", "stall cycle 4", stall, 1);
    tick(1);
    chk("R7", "stall released", stall, 0);
  endtask

  // R8 flash busy blocks
  task automatic t_flash();
    wreg(2'd0, 9'd8);
    wreg(2'd1, 9'h77);
    wreg(2'd2, 9'b100);
    flash_busy = 1'b1;
    wreg(2'd2, 9'b010);
    chk("R8", "no busy while flash busy", busy, 0);
    chk("R8", "no stall", stall, 0);
    flash_busy = 1'b0;
    tick(5);
    read_chk("R8", 9'd8, 8'h00);
  endtask

  // R9 order and reuse
  task automatic t_order();
    wreg(2'd1, 9'hC3);
    wreg(2'd0, 9'd511);
    wreg(2'd2, 9'b100);
    wreg(2'd2, 9'b010);
    chk("R9", "data-first start", busy, 1);
    wait_idle();
    wreg(2'd0, 9'd0);              // keep old data
    wreg(2'd2, 9'b100);
    wreg(2'd2, 9'b010);
    wait_idle();
    read_chk("R9", 9'd511, 8'hC3);
    read_chk("R9", 9'd0, 8'hC3);
  endtask

  // R10 latching, R11 read during busy
  task automatic t_busy_side();
    wreg(2'd0, 9'd20);
    wreg(2'd1, 9'h3C);
    wreg(2'd2, 9'b001);            // read 20 (prior content 0) sets rd_data
    chk("R11", "baseline read", rd_data, 8'h00);
    wreg(2'd2, 9'b100);
    wreg(2'd2, 9'b010);
    wreg(2'd0, 9'd21);
    wreg(2'd1, 9'hFF);
    wreg(2'd2, 9'b001);
    chk("R11", "rd_err pulse", rd_err, 1);
    chk("R11", "rd_data stale", rd_data, 8'h00);
    tick(1);
    chk("R11", "rd_err one cycle", rd_err, 0);
    wait_idle();
    read_chk("R10", 9'd20, 8'h3C);
    read_chk("R10", 9'd21, 8'h00);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1", "armed", armed, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "stall", stall, 0);
    chk("R1", "rd_err", rd_err, 0);
    chk("R1", "rd_data", rd_data, 0);
    // Clear the cells the bench reads before writing.
    foreach (init_addrs[i]) begin end
    t_clear(9'd7); t_clear(9'd8); t_clear(9'd20); t_clear(9'd21);
    t_basic_write();
    t_timeout();
    t_read_stall();
    t_flash();
    t_order();
    t_busy_side();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int init_addrs[1] = '{0};

  task automatic t_clear(input logic [8:0] a);
    wreg(2'd0, a);
    wreg(2'd1, 9'h00);
    wreg(2'd2, 9'b100);
    wreg(2'd2, 9'b010);
    wait_idle();
  endtask
endmodule